// File: doc/BRIEF.md
# Byte-Lane Save-RAM Adapter

This block places an 8-bit save RAM behind a 16-bit big-endian processor bus. The RAM can be wired to both byte lanes, to the upper (even) lane only, or to the lower (odd) lane only. A mode input selects the wiring. Each request is a word or byte read or write. The block masks the request address, drives the RAM address, write strobe and write byte, and assembles the 16-bit read result.

In a half-lane mode each RAM byte covers one bus word. The RAM index is the masked bus address shifted right by one, and the lane that is not wired always reads as all ones. Writes reach the RAM only when an external write-enable is asserted. A both-lane word access needs two RAM cycles, so a ready/response handshake holds the bus until the access completes. The RAM has a one-cycle read latency.

Top module: `save_lane_adapter`

## Requirements
- R1: The request address is ANDed with `addrMask` when the request is accepted, and every RAM index is derived from the masked value.
- R2: In both-lane mode (`laneMode`=00), a word access uses two consecutive RAM cycles. The first cycle is at the masked address with bit 0 cleared and carries data bits 15:8. The second cycle is at that address with bit 0 set and carries bits 7:0. A word read returns the first byte in bits 15:8 and the second in bits 7:0.
- R3: In both-lane mode a byte access uses the masked address directly. A byte read returns the byte in `rspData[7:0]`, with bits 15:8 equal to 0x00. A byte write stores `reqWdata[7:0]`.
- R4: In even-lane mode (`laneMode`=01), a word access uses RAM index = masked address >> 1. A read returns that byte in bits 15:8 and 0xFF in bits 7:0. A write stores bits 15:8.
- R5: In odd-lane mode (`laneMode`=10), a word access uses RAM index = masked address >> 1. A read returns 0xFF in bits 15:8 and that byte in bits 7:0. A write stores bits 7:0.
- R6: In a half-lane mode, a byte access on the unwired parity behaves as follows. Even mode with bit 0 = 1, or odd mode with bit 0 = 0, reads 0x00FF and leaves the RAM unchanged on a write. A byte access on the wired parity uses index = masked address >> 1.
- R7: No RAM write happens unless `wrEnable` was 1 when the request was accepted.
- R8: Mode 11 is undefined. A word read returns 0xFFFF, a byte read returns 0x00FF, and writes never reach the RAM.
- R9: `reqReady` is 1 only while the block is idle. Each accepted request yields exactly one single-cycle `rspValid` pulse. A write's response carries 0xFFFF for a word and 0x00FF for a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle, request accepted on this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWord | input | 1 | 1 = word access, 0 = byte access |
| reqAddr | input | ADDR_W | Bus byte address |
| reqWdata | input | 16 | Write data (byte writes use bits 7:0) |
| laneMode | input | 2 | 00 both lanes, 01 even lane, 10 odd lane, 11 undefined |
| addrMask | input | ADDR_W | Address mask |
| wrEnable | input | 1 | External write permission |
| rspValid | output | 1 | Response pulse |
| rspData | output | 16 | Read result |
| ramEn | output | 1 | RAM cycle active |
| ramWe | output | 1 | RAM write strobe |
| ramAddr | output | ADDR_W | RAM byte index |
| ramWdata | output | 8 | RAM write byte |
| ramRdata | input | 8 | RAM read byte, valid one cycle after the address |

## Verification
The hardest behaviour to observe is a discarded write. A byte write on the unwired lane, a write with `wrEnable` low, or a write in mode 11 leaves nothing visible on the response. The bench therefore reads the affected RAM byte back through both-lane mode at the index the write would have hit, and compares it against a shadow copy kept by the scoreboard. The two-cycle byte order of a both-lane word write shows only on the RAM side, so the bench RAM logs every write, and the log is checked for address and data order.

// File: rtl/save_lane_pkg.sv
package save_lane_pkg;

  typedef enum logic [1:0] {
    LANE_BOTH = 2'b00,
    LANE_EVEN = 2'b01,
    LANE_ODD  = 2'b10,
    LANE_NONE = 2'b11
  } laneMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;
    logic ramActive;
    logic secondByte;
    logic capFirst;
    logic capLast;
  } ctrlStrobe_t;

endpackage

// File: rtl/save_lane_ctrl.sv
module save_lane_ctrl
  import save_lane_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        needSecond,
  output ctrlStrobe_t strobe,
  output logic        reqReady,
  output logic        rspValid
);

  typedef enum logic [2:0] {ST_IDLE, ST_ACC_A, ST_ACC_B, ST_FIN, ST_RESP} state_e;
  state_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (reqValid) stateNext = ST_ACC_A;
      ST_ACC_A: stateNext = needSecond ? ST_ACC_B : ST_FIN;
      ST_ACC_B: stateNext = ST_FIN;
      ST_FIN:   stateNext = ST_RESP;
      ST_RESP:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.latchReq   = (state == ST_IDLE) && reqValid;
    strobe.ramActive  = (state == ST_ACC_A) || (state == ST_ACC_B);
    strobe.secondByte = (state == ST_ACC_B);
    strobe.capFirst   = (state == ST_ACC_B);
    strobe.capLast    = (state == ST_FIN);
  end

  assign reqReady = (state == ST_IDLE);
  assign rspValid = (state == ST_RESP);

endmodule

// File: rtl/save_lane_dp.sv
module save_lane_dp
  import save_lane_pkg::*;
#(
  parameter int ADDR_W = 10
)(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              reqWrite,
  input  logic              reqWord,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [15:0]       reqWdata,
  input  logic [1:0]        laneMode,
  input  logic [ADDR_W-1:0] addrMask,
  input  logic              wrEnable,
  input  logic [7:0]        ramRdata,
  output logic              needSecond,
  output logic              ramEn,
  output logic              ramWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [7:0]        ramWdata,
  output logic [15:0]       rspData,
  output logic [1:0]        modeOut,
  output logic              wenOut
);

  localparam int HI_W = ADDR_W - 1;

  logic [ADDR_W-1:0] addrQ;
  logic [15:0]       wdataQ;
  logic              wordQ, writeQ, wenQ;
  laneMode_e         modeQ;
  logic [7:0]        rdHi, rdLo;
  logic              laneOk;
  logic [ADDR_W-1:0] halfIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      wordQ  <= 1'b0;
      writeQ <= 1'b0;
      wenQ   <= 1'b0;
      modeQ  <= LANE_NONE;
      rdHi   <= 8'hFF;
      rdLo   <= 8'hFF;
    end else if (strobe.latchReq) begin
      addrQ  <= reqAddr & addrMask;
      wdataQ <= reqWdata;
      wordQ  <= reqWord;
      writeQ <= reqWrite;
      wenQ   <= wrEnable;
      modeQ  <= laneMode_e'(laneMode);
      rdHi   <= 8'hFF;
      rdLo   <= 8'hFF;
    end else if (!writeQ && laneOk) begin
      if (strobe.capFirst) rdHi <= ramRdata;
      if (strobe.capLast) begin
        if (needSecond || !wordQ || modeQ == LANE_ODD) rdLo <= ramRdata;
        else                                            rdHi <= ramRdata;
      end
    end
  end

  always_comb begin
    unique case (modeQ)
      LANE_BOTH: laneOk = 1'b1;
      LANE_EVEN: laneOk = wordQ || !addrQ[0];
      LANE_ODD:  laneOk = wordQ ||  addrQ[0];
      default:   laneOk = 1'b0;
    endcase
  end

  assign needSecond = (modeQ == LANE_BOTH) && wordQ;
  assign halfIdx    = {1'b0, addrQ[ADDR_W-1:1]};

  always_comb begin
    if (!strobe.ramActive)     ramAddr = '0;
    else if (modeQ == LANE_BOTH)
      ramAddr = wordQ ? {addrQ[ADDR_W-1:ADDR_W-HI_W], strobe.secondByte} : addrQ;
    else                       ramAddr = halfIdx;
  end

  always_comb begin
    if (needSecond)
      ramWdata = strobe.secondByte ? wdataQ[7:0] : wdataQ[15:8];
    else if (wordQ && modeQ == LANE_EVEN)
      ramWdata = wdataQ[15:8];
    else
      ramWdata = wdataQ[7:0];
  end

  assign ramEn   = strobe.ramActive;
  assign ramWe   = strobe.ramActive && writeQ && wenQ && laneOk;
  assign rspData = wordQ ? {rdHi, rdLo} : {8'h00, rdLo};
  assign modeOut = modeQ;
  assign wenOut  = wenQ;

endmodule

// File: rtl/save_lane_adapter.sv
module save_lane_adapter
  import save_lane_pkg::*;
#(
  parameter int ADDR_W = 10
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic              reqWord,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [15:0]       reqWdata,
  input  logic [1:0]        laneMode,
  input  logic [ADDR_W-1:0] addrMask,
  input  logic              wrEnable,
  output logic              rspValid,
  output logic [15:0]       rspData,
  output logic              ramEn,
  output logic              ramWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [7:0]        ramWdata,
  input  logic [7:0]        ramRdata
);

  ctrlStrobe_t strobe;
  logic        needSecond;
  logic [1:0]  modeQ;
  logic        wenQ;

  save_lane_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .needSecond(needSecond),
    .strobe(strobe), .reqReady(reqReady), .rspValid(rspValid)
  );

  save_lane_dp #(.ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqWrite(reqWrite), .reqWord(reqWord), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .laneMode(laneMode), .addrMask(addrMask),
    .wrEnable(wrEnable), .ramRdata(ramRdata), .needSecond(needSecond),
    .ramEn(ramEn), .ramWe(ramWe), .ramAddr(ramAddr), .ramWdata(ramWdata),
    .rspData(rspData), .modeOut(modeQ), .wenOut(wenQ)
  );

endmodule

// File: rtl/save_lane_checker.sv
module save_lane_checker #(
  parameter int ADDR_W = 10
)(
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              rspValid,
  input logic              ramEn,
  input logic              ramWe,
  input logic [ADDR_W-1:0] ramAddr,
  input logic [1:0]        modeQ,
  input logic              wenQ
);

  p_we_gated_r7: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> wenQ);

  p_none_no_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (modeQ != 2'b11));

  p_word_order_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ramEn && $past(ramEn)) |-> ((ramAddr == ($past(ramAddr) | ADDR_W'(1))) && !$past(ramAddr[0])));

  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  p_we_in_cycle_r7: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> ramEn);

endmodule

bind save_lane_adapter save_lane_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .rspValid(rspValid), .ramEn(ramEn), .ramWe(ramWe), .ramAddr(ramAddr),
  .modeQ(modeQ), .wenQ(wenQ)
);

// File: tb/save_lane_adapter_tb.sv
`timescale 1ns/1ps
module save_lane_adapter_tb_top;

  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqWord = 1'b0, wrEnable = 1'b0;
  logic [AW-1:0] reqAddr = '0, addrMask = '1;
  logic [15:0] reqWdata = '0;
  logic [1:0] laneMode = 2'b00;
  logic reqReady, rspValid, ramEn, ramWe;
  logic [15:0] rspData;
  logic [AW-1:0] ramAddr;
  logic [7:0] ramWdata;
  logic [7:0] ramRdata;

  always #4 clk = ~clk;

  save_lane_adapter #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqWord(reqWord), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .laneMode(laneMode), .addrMask(addrMask),
    .wrEnable(wrEnable), .rspValid(rspValid), .rspData(rspData),
    .ramEn(ramEn), .ramWe(ramWe), .ramAddr(ramAddr), .ramWdata(ramWdata),
    .ramRdata(ramRdata)
  );

  // bench RAM with one-cycle read latency and a write log
  logic [7:0] ram [DEPTH];
  logic [AW-1:0] wrAddrLog[$];
  logic [7:0] wrDataLog[$];

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) ram[i] <= 8'(i * 37 + 5);
      ramRdata <= 8'h00;
    end else begin
      if (ramWe) begin
        ram[ramAddr] <= ramWdata;
        wrAddrLog.push_back(ramAddr);
        wrDataLog.push_back(ramWdata);
      end
      ramRdata <= ram[ramAddr];
    end
  end

  // scoreboard state
  logic [7:0] shadow [DEPTH];
  logic [15:0] expQ[$];
  string tagQ[$];
  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected result and shadow update from the requirements
  task automatic modelReq(input bit wr, input bit word, input logic [AW-1:0] addr,
                          input logic [15:0] wd, input logic [1:0] mode,
                          input logic [AW-1:0] mask, input bit wen,
                          output logic [15:0] exp);
    logic [AW-1:0] m, idx, a0, a1;
    m   = addr & mask;
    idx = m >> 1;
    a0  = {m[AW-1:1], 1'b0};
    a1  = {m[AW-1:1], 1'b1};
    exp = word ? 16'hFFFF : 16'h00FF;
    case (mode)
      2'b00: begin
        if (word) begin
          if (wr) begin if (wen) begin shadow[a0] = wd[15:8]; shadow[a1] = wd[7:0]; end end
          else exp = {shadow[a0], shadow[a1]};
        end else begin
          if (wr) begin if (wen) shadow[m] = wd[7:0]; end
          else exp = {8'h00, shadow[m]};
        end
      end
      2'b01: begin
        if (word) begin
          if (wr) begin if (wen) shadow[idx] = wd[15:8]; end
          else exp = {shadow[idx], 8'hFF};
        end else if (!m[0]) begin
          if (wr) begin if (wen) shadow[idx] = wd[7:0]; end
          else exp = {8'h00, shadow[idx]};
        end
      end
      2'b10: begin
        if (word) begin
          if (wr) begin if (wen) shadow[idx] = wd[7:0]; end
          else exp = {8'hFF, shadow[idx]};
        end else if (m[0]) begin
          if (wr) begin if (wen) shadow[idx] = wd[7:0]; end
          else exp = {8'h00, shadow[idx]};
        end
      end
      default: ;
    endcase
  endtask

  task automatic doReq(input bit wr, input bit word, input logic [AW-1:0] addr,
                       input logic [15:0] wd, input logic [1:0] mode,
                       input logic [AW-1:0] mask, input bit wen, input string tag);
    logic [15:0] exp;
    modelReq(wr, word, addr, wd, mode, mask, wen, exp);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqWrite = wr; reqWord = word; reqAddr = addr; reqWdata = wd;
    laneMode = mode; addrMask = mask; wrEnable = wen; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    wait (expQ.size() == 0);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R9 unexpected response", rspData, 16'h0000);
      end else begin
        logic [15:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(rspData === e, t, rspData, e);
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      finished = 1;
      nFails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  localparam logic [AW-1:0] FULL = '1;

  initial begin
    for (int i = 0; i < DEPTH; i++) shadow[i] = 8'(i * 37 + 5);
    repeat (5) @(posedge clk);
    @(negedge clk);
    // reset state
    check(reqReady === 1'b1, "R9 reset reqReady", {15'h0, reqReady}, 16'h1);
    check(rspValid === 1'b0, "R9 reset rspValid", {15'h0, rspValid}, 16'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(ramWe === 1'b0, "R7 idle ramWe", {15'h0, ramWe}, 16'h0);

    // R2: both-lane word write order and readback
    wrAddrLog.delete(); wrDataLog.delete();
    doReq(1, 1, 10'h010, 16'h1234, 2'b00, FULL, 1, "R9 word write rsp");
    check(wrAddrLog.size() == 2, "R2 two RAM writes", 16'(wrAddrLog.size()), 16'd2);
    if (wrAddrLog.size() == 2) begin
      check(wrAddrLog[0] == 10'h010 && wrDataLog[0] == 8'h12, "R2 first write hi",
            {wrDataLog[0], 6'h0, wrAddrLog[0][1:0]}, 16'h1200);
      check(wrAddrLog[1] == 10'h011 && wrDataLog[1] == 8'h34, "R2 second write lo",
            {wrDataLog[1], 6'h0, wrAddrLog[1][1:0]}, 16'h3401);
    end
    doReq(0, 1, 10'h010, 16'h0, 2'b00, FULL, 0, "R2 word read");
    doReq(0, 1, 10'h011, 16'h0, 2'b00, FULL, 0, "R2 word read odd addr");
    // R3 byte access
    doReq(0, 0, 10'h011, 16'h0, 2'b00, FULL, 0, "R3 byte read");
    doReq(1, 0, 10'h013, 16'h00AB, 2'b00, FULL, 1, "R3 byte write rsp");
    doReq(0, 1, 10'h012, 16'h0, 2'b00, FULL, 0, "R3 byte write readback");
    // R1 mask
    doReq(1, 1, 10'h3F0, 16'h5A6B, 2'b00, 10'h0FF, 1, "R1 masked write rsp");
    doReq(0, 1, 10'h0F0, 16'h0, 2'b00, FULL, 0, "R1 masked readback");
    doReq(0, 0, 10'h2F1, 16'h0, 2'b00, 10'h0FF, 0, "R1 masked byte read");
    // R4 even lane
    doReq(1, 1, 10'h040, 16'hC399, 2'b01, FULL, 1, "R4 even write rsp");
    doReq(0, 1, 10'h040, 16'h0, 2'b01, FULL, 0, "R4 even word read");
    doReq(0, 0, 10'h020, 16'h0, 2'b00, FULL, 0, "R4 even stored hi byte");
    doReq(0, 0, 10'h040, 16'h0, 2'b01, FULL, 0, "R6 even byte wired");
    doReq(0, 0, 10'h041, 16'h0, 2'b01, FULL, 0, "R6 even byte unwired read");
    doReq(1, 0, 10'h041, 16'h0077, 2'b01, FULL, 1, "R6 even unwired write rsp");
    doReq(0, 0, 10'h020, 16'h0, 2'b00, FULL, 0, "R6 even unwired write discarded");
    // R5 odd lane
    doReq(1, 1, 10'h060, 16'h99E7, 2'b10, FULL, 1, "R5 odd write rsp");
    doReq(0, 1, 10'h060, 16'h0, 2'b10, FULL, 0, "R5 odd word read");
    doReq(0, 0, 10'h030, 16'h0, 2'b00, FULL, 0, "R5 odd stored lo byte");
    doReq(0, 0, 10'h061, 16'h0, 2'b10, FULL, 0, "R6 odd byte wired");
    doReq(1, 0, 10'h060, 16'h0011, 2'b10, FULL, 1, "R6 odd unwired write rsp");
    doReq(0, 0, 10'h030, 16'h0, 2'b00, FULL, 0, "R6 odd unwired write discarded");
    doReq(1, 0, 10'h063, 16'h0022, 2'b10, FULL, 1, "R6 odd wired write rsp");
    doReq(0, 0, 10'h031, 16'h0, 2'b00, FULL, 0, "R6 odd wired write stored");
    // R7 write enable
    doReq(1, 1, 10'h080, 16'hDEAD, 2'b00, FULL, 0, "R7 disabled write rsp");
    doReq(0, 1, 10'h080, 16'h0, 2'b00, FULL, 0, "R7 disabled write ignored");
    doReq(1, 1, 10'h090, 16'hBEEF, 2'b01, FULL, 0, "R7 disabled even write rsp");
    doReq(0, 0, 10'h048, 16'h0, 2'b00, FULL, 0, "R7 disabled even write ignored");
    // R8 undefined mode
    doReq(0, 1, 10'h010, 16'h0, 2'b11, FULL, 0, "R8 undefined word read");
    doReq(0, 0, 10'h011, 16'h0, 2'b11, FULL, 0, "R8 undefined byte read");
    doReq(1, 1, 10'h010, 16'h4444, 2'b11, FULL, 1, "R8 undefined write rsp");
    doReq(0, 1, 10'h010, 16'h0, 2'b00, FULL, 0, "R8 undefined write ignored");

    @(negedge clk);
    check(expQ.size() == 0 && rspValid === 1'b0, "R9 no extra response",
          16'(expQ.size()), 16'h0);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule